// File: doc/BRIEF.md
# Strap-Configured Management Register Bridge

This block sits behind a management-bus slave port whose frames are already decoded. Each host request carries a 5-bit external device address, a 5-bit register number, a direction and 16 bits of write data. From four strap pins and a dual-chip mode input, the block decides whether the request belongs to this chip. Claimed accesses are carried to an internal register bus that reaches up to 32 internal devices. Internal devices answer with a request/acknowledge handshake that may take any number of cycles.

Three addressing schemes are chosen while the block runs. With the dual-chip input low and all straps low, every external address is claimed and passed straight through. With the dual-chip input low and a non-zero strap value, only one even address is claimed. At that address the host sees a small window: a command register with a self-clearing busy bit and a data register. The host uses these two registers to reach any internal device indirectly. With the dual-chip input high, half of the address space is claimed, so two chips can share one bus.

In the two direct schemes, `h_ready` falls while an access is in flight. In the window scheme, the host polls the busy bit instead.

Top module: `strap_reg_bridge`

## Requirements
- R1: After reset `ib_req` and `h_rvalid` are 0, `h_ready` is 1, and the command register reads 0x0000.
- R2: With `dual_mode`=0 and `strap`=0, every external address is claimed. The access goes out with `ib_dev` equal to `h_dev` and `ib_reg` equal to `h_reg`. For a read, `h_rvalid` pulses with the returned word on the cycle after `ib_ack`.
- R3: With `dual_mode`=0 and `strap`≠0, only external address {strap,0} is claimed. Requests to any other address produce no `h_rvalid` and no internal access.
- R4: With `dual_mode`=1, an address is claimed when its bit 4 equals `strap[3]`. The address then maps to internal device number equal to its bits 3:0.
- R5: In the window, register 0 is the command register. Writing it with bit 15 set, bit 12 set and opcode bits 11:10 equal to 01 (write) or 10 (read) starts one internal access. That access goes to device bits 9:5 and register bits 4:0. Bit 15 reads back as 1 until the cycle after `ib_ack`, and the other bits read back as written.
- R6: An indirect write sends the value held in the window's data register (register 1), with `ib_we`=1.
- R7: An indirect read captures `ib_rdata` into the data register on the `ib_ack` cycle; a later read of register 1 returns it.
- R8: A command with bit 15 set but bit 12 clear, or with opcode 00 or 11, makes no internal access. It is stored with bit 15 cleared.
- R9: Host writes to the command or data register are ignored while bit 15 is set, including the `ib_ack` cycle itself.
- R10: Window reads respond on the next cycle. Registers 2 to 31 of the window read 0x0000.
- R11: In the direct schemes, `h_ready` is low from the cycle after a claimed request is accepted until the cycle after `ib_ack`. While an internal access is in flight, `ib_req` and its address, direction and data stay stable until `ib_ack`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| strap | input | 4 | Strapped address bits 4:1 (bit 0 is always 0) |
| dual_mode | input | 1 | Selects half-space dual-chip addressing |
| h_req | input | 1 | Host request, taken when `h_ready` is high |
| h_we | input | 1 | Host request is a write |
| h_dev | input | 5 | External device address |
| h_reg | input | 5 | Register number |
| h_wdata | input | 16 | Host write data |
| h_ready | output | 1 | Block can take a request |
| h_rvalid | output | 1 | One-cycle read response strobe |
| h_rdata | output | 16 | Read response data |
| ib_req | output | 1 | Internal access request, held until acknowledged |
| ib_we | output | 1 | Internal access is a write |
| ib_dev | output | 5 | Internal device number |
| ib_reg | output | 5 | Internal register number |
| ib_wdata | output | 16 | Internal write data |
| ib_ack | input | 1 | Internal access complete |
| ib_rdata | input | 16 | Internal read data, valid with `ib_ack` |

## Verification
In the window scheme, the internal acknowledge and a host access to the window can land on the same clock edge. The bench provokes this by taking manual control of `ib_ack` and driving it at the same falling edge as a host request. In one run the host writes the data register on the acknowledge edge. The data register must then hold the internal word, not the host value, because busy is still set on that edge. In another run the host reads the command register on the acknowledge edge and must still see bit 15 set, then see it clear on the next read.

// File: rtl/strap_reg_bridge.sv
module strap_reg_bridge (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [3:0]  strap,
  input  logic        dual_mode,
  input  logic        h_req,
  input  logic        h_we,
  input  logic [4:0]  h_dev,
  input  logic [4:0]  h_reg,
  input  logic [15:0] h_wdata,
  output logic        h_ready,
  output logic        h_rvalid,
  output logic [15:0] h_rdata,
  output logic        ib_req,
  output logic        ib_we,
  output logic [4:0]  ib_dev,
  output logic [4:0]  ib_reg,
  output logic [15:0] ib_wdata,
  input  logic        ib_ack,
  input  logic [15:0] ib_rdata
);
  localparam int BUSY   = 15;
  localparam int CLAUSE = 12;
  localparam logic [1:0] OP_WR = 2'b01;
  localparam logic [1:0] OP_RD = 2'b10;

  logic [15:0] cmd_q, data_q;
  logic        dir_busy;

  wire       win     = !dual_mode && (strap != 4'd0);
  wire [4:0] own     = {strap, 1'b0};
  wire       claim   = dual_mode ? (h_dev[4] == strap[3]) : (!win || h_dev == own);
  wire [4:0] map_dev = dual_mode ? {1'b0, h_dev[3:0]} : h_dev;
  wire       busy    = cmd_q[BUSY];
  wire       cmd_ok  = h_wdata[CLAUSE] && (h_wdata[11:10] == OP_WR || h_wdata[11:10] == OP_RD);
  wire       done    = ib_req && ib_ack;

  assign h_ready = !ib_req || (win && !dir_busy);
  wire   accept  = h_req && h_ready && claim;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmd_q    <= '0;
      data_q   <= '0;
      dir_busy <= 1'b0;
      h_rvalid <= 1'b0;
      h_rdata  <= '0;
      ib_req   <= 1'b0;
      ib_we    <= 1'b0;
      ib_dev   <= '0;
      ib_reg   <= '0;
      ib_wdata <= '0;
    end else begin
      h_rvalid <= 1'b0;
      if (done) begin
        ib_req <= 1'b0;
        if (dir_busy) begin
          dir_busy <= 1'b0;
          if (!ib_we) begin
            h_rvalid <= 1'b1;
            h_rdata  <= ib_rdata;
          end
        end else begin
          cmd_q[BUSY] <= 1'b0;
          if (!ib_we) data_q <= ib_rdata;
        end
      end
      if (accept) begin
        if (!win) begin
          dir_busy <= 1'b1;
          ib_req   <= 1'b1;
          ib_we    <= h_we;
          ib_dev   <= map_dev;
          ib_reg   <= h_reg;
          ib_wdata <= h_wdata;
        end else if (!h_we) begin
          h_rvalid <= 1'b1;
          h_rdata  <= (h_reg == 5'd0) ? cmd_q : (h_reg == 5'd1) ? data_q : 16'h0000;
        end else if (!busy) begin
          if (h_reg == 5'd0) begin
            if (h_wdata[BUSY] && cmd_ok) begin
              cmd_q    <= h_wdata;
              ib_req   <= 1'b1;
              ib_we    <= (h_wdata[11:10] == OP_WR);
              ib_dev   <= h_wdata[9:5];
              ib_reg   <= h_wdata[4:0];
              ib_wdata <= data_q;
            end else begin
              cmd_q <= {1'b0, h_wdata[14:0]};
            end
          end else if (h_reg == 5'd1) begin
            data_q <= h_wdata;
          end
        end
      end
    end
  end
endmodule

// File: rtl/strap_reg_bridge_chk.sv
module strap_reg_bridge_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        h_ready,
  input logic        ib_req,
  input logic        ib_ack,
  input logic        ib_we,
  input logic [4:0]  ib_dev,
  input logic [4:0]  ib_reg,
  input logic [15:0] ib_wdata,
  input logic        busy
);
  a_r11_not_ready_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
    !h_ready |-> ib_req);
  a_r11_req_held: assert property (@(posedge clk) disable iff (!rst_n)
    ib_req && !ib_ack |=> ib_req);
  a_r11_fields_stable: assert property (@(posedge clk) disable iff (!rst_n)
    ib_req && !ib_ack |=> $stable(ib_we) && $stable(ib_dev) && $stable(ib_reg) && $stable(ib_wdata));
  a_r5_ack_ends_req: assert property (@(posedge clk) disable iff (!rst_n)
    ib_req && ib_ack |=> !ib_req);
  a_r5_busy_has_req: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> ib_req);
  a_r9_busy_kept: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !ib_ack |=> busy);
endmodule

bind strap_reg_bridge strap_reg_bridge_chk u_chk (
  .clk(clk), .rst_n(rst_n), .h_ready(h_ready), .ib_req(ib_req), .ib_ack(ib_ack),
  .ib_we(ib_we), .ib_dev(ib_dev), .ib_reg(ib_reg), .ib_wdata(ib_wdata), .busy(cmd_q[15])
);

// File: tb/sim_strap_reg_bridge.sv
module sim_strap_reg_bridge;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [3:0] strap = 4'd0;
  logic dual_mode = 1'b0, h_req = 1'b0, h_we = 1'b0;
  logic [4:0] h_dev = '0, h_reg = '0;
  logic [15:0] h_wdata = '0;
  logic h_ready, h_rvalid, ib_req, ib_we;
  logic [15:0] h_rdata, ib_wdata;
  logic [4:0] ib_dev, ib_reg;
  logic ib_ack = 1'b0;
  logic [15:0] ib_rdata = '0;

  int checks = 0, errors = 0, dly = 0, cnt = 0, acks = 0;
  bit manual = 1'b0, finished = 1'b0;
  logic [4:0] w_dev, w_reg;
  logic [15:0] w_data;

  always #4 clk = ~clk;

  strap_reg_bridge u0 (.*);

  function automatic logic [15:0] mdl(input logic [4:0] d, input logic [4:0] r);
    return {1'b1, d, r, 5'h15};
  endfunction

  always @(negedge clk) begin
    if (!manual) begin
      if (ib_ack) begin
        ib_ack = 1'b0;
        cnt = 0;
      end else if (ib_req) begin
        if (cnt >= dly) begin
          ib_ack = 1'b1;
          ib_rdata = mdl(ib_dev, ib_reg);
          if (ib_we) begin
            w_dev = ib_dev; w_reg = ib_reg; w_data = ib_wdata;
          end
          acks++;
          cnt = 0;
        end else cnt++;
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wait_ready();
    for (int i = 0; i < 50 && !h_ready; i++) @(negedge clk);
  endtask

  task automatic hwrite(input logic [4:0] d, input logic [4:0] r, input logic [15:0] v);
    wait_ready();
    h_req = 1; h_we = 1; h_dev = d; h_reg = r; h_wdata = v;
    @(negedge clk);
    h_req = 0; h_we = 0;
    wait_ready();
  endtask

  task automatic hread(input logic [4:0] d, input logic [4:0] r,
                       output bit got, output logic [15:0] v, output int cyc);
    wait_ready();
    h_req = 1; h_we = 0; h_dev = d; h_reg = r;
    @(negedge clk);
    h_req = 0;
    cyc = 0;
    while (!h_rvalid && cyc < 20) begin @(negedge clk); cyc++; end
    got = h_rvalid; v = h_rdata;
    @(negedge clk);
  endtask

  task automatic poll_idle(input logic [4:0] d, output logic [15:0] v);
    bit g; int c;
    v = 16'h8000;
    for (int i = 0; i < 40 && v[15]; i++) hread(d, 5'd0, g, v, c);
  endtask

  task automatic t_reset();
    chk(h_ready == 1 && h_rvalid == 0 && ib_req == 0, "R1 reset outputs",
        {13'd0, h_ready, h_rvalid, ib_req}, 16'h0004);
  endtask

  task automatic t_single();
    bit g; logic [15:0] v; int c;
    strap = 0; dual_mode = 0; dly = 4;
    hread(5'd7, 5'd3, g, v, c);
    chk(g && v == mdl(7, 3), "R2 single read data", v, mdl(7, 3));
    chk(c == dly + 1, "R2 read latency", 16'(c), 16'(dly + 1));
    dly = 2;
    hwrite(5'd31, 5'd30, 16'hBEEF);
    chk(w_dev == 31 && w_reg == 30 && w_data == 16'hBEEF, "R2 single write fields",
        {1'b0, w_dev, w_reg, 5'd0}, {1'b0, 5'd31, 5'd30, 5'd0});
    dly = 3;
    h_req = 1; h_we = 1; h_dev = 5'd2; h_reg = 5'd1; h_wdata = 16'h0042;
    @(negedge clk);
    h_req = 0; h_we = 0;
    chk(!h_ready && ib_req, "R11 ready low in flight", {14'd0, h_ready, ib_req}, 16'h0001);
    wait_ready();
    chk(h_ready == 1 && w_data == 16'h0042, "R11 ready back after ack", w_data, 16'h0042);
  endtask

  task automatic t_dual();
    bit g; logic [15:0] v; int c; int a0;
    dual_mode = 1; strap = 4'b1000; dly = 1;
    hread(5'd21, 5'd2, g, v, c);
    chk(g && v == mdl(5, 2), "R4 upper half maps to device n", v, mdl(5, 2));
    a0 = acks;
    hread(5'd3, 5'd2, g, v, c);
    chk(!g && acks == a0, "R4 lower half unclaimed", {15'd0, g}, 16'd0);
    hwrite(5'd25, 5'd6, 16'h7777);
    chk(w_dev == 9 && w_reg == 6, "R4 dual write device", {11'd0, w_dev}, 16'd9);
    strap = 4'b0000;
    hread(5'd3, 5'd4, g, v, c);
    chk(g && v == mdl(3, 4), "R4 lower base claims low half", v, mdl(3, 4));
  endtask

  task automatic t_multi();
    bit g; logic [15:0] v; int c; int a0;
    dual_mode = 0; strap = 4'b0011; dly = 5;
    hread(5'd6, 5'd0, g, v, c);
    chk(g && v == 16'h0000, "R1 command reads zero", v, 16'h0000);
    a0 = acks;
    hread(5'd7, 5'd0, g, v, c);
    chk(!g, "R3 odd neighbour unclaimed", {15'd0, g}, 16'd0);
    hread(5'd0, 5'd3, g, v, c);
    chk(!g && acks == a0, "R3 address 0 unclaimed", {15'd0, g}, 16'd0);
    hread(5'd6, 5'd5, g, v, c);
    chk(g && v == 16'h0000 && c == 0, "R10 unused register reads zero next cycle", v, 16'h0000);
    hwrite(5'd6, 5'd1, 16'h1234);
    hwrite(5'd6, 5'd0, 16'h9544);
    hread(5'd6, 5'd0, g, v, c);
    chk(v == 16'h9544, "R5 busy set after command", v, 16'h9544);
    poll_idle(5'd6, v);
    chk(v == 16'h1544, "R5 busy self clears", v, 16'h1544);
    chk(w_dev == 10 && w_reg == 4 && w_data == 16'h1234, "R6 indirect write uses data reg",
        w_data, 16'h1234);
    dly = 6;
    hwrite(5'd6, 5'd0, 16'h9867);
    hwrite(5'd6, 5'd1, 16'hAAAA);
    hwrite(5'd6, 5'd0, 16'h0000);
    poll_idle(5'd6, v);
    chk(v == 16'h1867, "R9 command write ignored while busy", v, 16'h1867);
    hread(5'd6, 5'd1, g, v, c);
    chk(v == mdl(3, 7), "R7 indirect read result", v, mdl(3, 7));
    a0 = acks;
    hwrite(5'd6, 5'd0, 16'h9C21);
    hread(5'd6, 5'd0, g, v, c);
    chk(v == 16'h1C21 && acks == a0 && !ib_req, "R8 opcode 11 no access", v, 16'h1C21);
    hwrite(5'd6, 5'd0, 16'h8421);
    hread(5'd6, 5'd0, g, v, c);
    chk(v == 16'h0421 && acks == a0, "R8 clause bit clear no access", v, 16'h0421);
  endtask

  task automatic t_same_cycle();
    bit g; logic [15:0] v; int c;
    manual = 1;
    hwrite(5'd6, 5'd0, 16'h9867);
    ib_ack = 1; ib_rdata = 16'h5A5A;
    h_req = 1; h_we = 1; h_dev = 5'd6; h_reg = 5'd1; h_wdata = 16'h1111;
    @(negedge clk);
    ib_ack = 0; h_req = 0; h_we = 0;
    hread(5'd6, 5'd1, g, v, c);
    chk(v == 16'h5A5A, "R9 data write on ack edge ignored", v, 16'h5A5A);
    hwrite(5'd6, 5'd0, 16'h9867);
    ib_ack = 1; ib_rdata = 16'h0F0F;
    h_req = 1; h_we = 0; h_dev = 5'd6; h_reg = 5'd0;
    @(negedge clk);
    ib_ack = 0; h_req = 0;
    chk(h_rvalid && h_rdata == 16'h9867, "R5 busy still seen on ack edge", h_rdata, 16'h9867);
    @(negedge clk);
    hread(5'd6, 5'd0, g, v, c);
    chk(v == 16'h1867, "R5 busy clear after ack", v, 16'h1867);
    manual = 0;
  endtask

  task automatic t_switch();
    bit g; logic [15:0] v; int c;
    strap = 0; dly = 0;
    hread(5'd6, 5'd0, g, v, c);
    chk(g && v == mdl(6, 0), "R2 run-time switch to single", v, mdl(6, 0));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_single();
    t_dual();
    t_multi();
    t_same_cycle();
    t_switch();
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule